// File: doc/BRIEF.md
# Load Result Formatter

This unit sits between the data a memory port returns and the write port of the integer register file. It takes the raw bytes of a load and produces the 64-bit register value. The loaded bytes sit right-aligned in `raw_data`: a load of N bytes occupies `raw_data[8N-1:0]`, and the byte at the lowest address is the most significant byte of that field. Register bits are named in the big-endian way, so register bit 0 is `result[63]` and register bits 56:63 are `result[7:0]`.

Three controls select the formatting. The access size is 1, 2, 4 or 8 bytes. The extension is zero or sign. The byte-reverse flag mirrors the byte order of the field before the upper bits are zero-filled. Two combinations are meaningless: reversing a single byte, and reversing together with sign extension. Either one raises a flag and forces the value to zero. The result is offered combinationally. A registered copy is also provided, loaded on a valid strobe, for pipelines that want the value one stage later.

Top module: `load_result_fmt`

## Requirements
- R1: With `size`=0 (byte), `sign_ext`=0 and `byte_rev`=0, `comb_result` = {56'b0, raw_data[7:0]}.
- R2: With `size`=1 (halfword) or 2 (word), `sign_ext`=0 and `byte_rev`=0, `comb_result` holds raw_data[15:0] or raw_data[31:0] in its low bits, and every bit above them is 0.
- R3: With `sign_ext`=1, `byte_rev`=0 and `size` of 0, 1 or 2, `comb_result` is the 8-, 16- or 32-bit low field of raw_data, with its top bit copied into all the bits above it.
- R4: With `size`=3 (doubleword) and `byte_rev`=0, `comb_result` equals raw_data for either value of `sign_ext`.
- R5: With `size`=1, `byte_rev`=1 and `sign_ext`=0, `comb_result` = {48'b0, raw_data[7:0], raw_data[15:8]}.
- R6: With `size`=2, `byte_rev`=1 and `sign_ext`=0, `comb_result` = {32'b0, raw_data[7:0], raw_data[15:8], raw_data[23:16], raw_data[31:24]}.
- R7: With `size`=3, `byte_rev`=1 and `sign_ext`=0, the eight bytes of raw_data appear in `comb_result` in the reverse order: byte i of the result (bits 8i+7:8i) is byte 7-i of raw_data.
- R8: When `byte_rev`=1 together with `sign_ext`=1 or `size`=0, `comb_illegal`=1 and `comb_result`=0. Otherwise `comb_illegal`=0.
- R9: The raw_data bits above the selected access size have no effect on `comb_result`.
- R10: At a rising edge with `in_valid`=1, `out_result` and `out_illegal` take the values `comb_result` and `comb_illegal` had before that edge, and `out_valid` becomes 1. At a rising edge with `in_valid`=0, `out_valid` becomes 0 and `out_result` and `out_illegal` keep their values.
- R11: A rising edge with `rst`=1 sets `out_valid`, `out_result` and `out_illegal` to 0, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that loads the output register |
| raw_data | input | 64 | Loaded bytes, right-aligned |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| sign_ext | input | 1 | 1 selects sign extension, 0 selects zero fill |
| byte_rev | input | 1 | 1 mirrors the byte order of the field |
| comb_result | output | 64 | Formatted value, combinational |
| comb_illegal | output | 1 | Illegal control combination, combinational |
| out_valid | output | 1 | Registered strobe, in_valid delayed one cycle |
| out_result | output | 64 | Registered formatted value |
| out_illegal | output | 1 | Registered illegal flag |

## Verification
The combinational pair `comb_result` and `comb_illegal` settles in the same cycle as its inputs. The bench drives on the falling edge and samples that pair 2 ns later, before any rising edge. The registered outputs are due at the first rising edge after the stimulus, so the bench samples them 2 ns after that edge and before it drives the next vector. Cycles with the strobe low are checked on that same edge: the registered value must not change.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int LD_DATA_W = 64;
  localparam int LD_BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ld_size_e;
endpackage

// File: rtl/ldfmt_swap.sv
// Byte mirror of the low 2^k bytes, one network per size, picked by size.
module ldfmt_swap #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SIZES  = $clog2(NBYTES) + 1,
  localparam int SZ_W   = $clog2(SIZES)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SZ_W-1:0]   size,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rev_by_sz [SIZES];

  for (genvar k = 0; k < SIZES; k++) begin : g_size
    localparam int NB = 1 << k;
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      if (i < NB) begin : g_take
        assign rev_by_sz[k][i*BYTE_W +: BYTE_W] = din[(NB-1-i)*BYTE_W +: BYTE_W];
      end else begin : g_fill
        assign rev_by_sz[k][i*BYTE_W +: BYTE_W] = '0;
      end
    end
  end

  always_comb dout = rev_by_sz[size];
endmodule

// File: rtl/ldfmt_extend.sv
// Keeps the low field of the chosen size and fills above it with zero or sign.
module ldfmt_extend #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SIZES  = $clog2(NBYTES) + 1,
  localparam int SZ_W   = $clog2(SIZES)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SZ_W-1:0]   size,
  input  logic              sign,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] ext_by_sz [SIZES];

  for (genvar k = 0; k < SIZES; k++) begin : g_size
    localparam int FW = (1 << k) * BYTE_W;
    if (FW >= DATA_W) begin : g_full
      assign ext_by_sz[k] = din;
    end else begin : g_part
      logic [FW-1:0] fld;
      assign fld = din[FW-1:0];
      assign ext_by_sz[k] = sign ? {{(DATA_W-FW){fld[FW-1]}}, fld}
                                 : {{(DATA_W-FW){1'b0}}, fld};
    end
  end

  always_comb dout = ext_by_sz[size];
endmodule

// File: rtl/ldfmt_legal.sv
// Decodes the control combination into path selects and the illegal flag.
module ldfmt_legal #(
  parameter int SZ_W = 2
) (
  input  logic [SZ_W-1:0] size,
  input  logic            sign_ext,
  input  logic            byte_rev,
  output logic            use_rev,
  output logic            use_sign,
  output logic            illegal
);
  logic is_byte;
  always_comb begin
    is_byte  = (size == SZ_W'(0));
    illegal  = byte_rev & (sign_ext | is_byte);
    use_rev  = byte_rev & ~illegal;
    use_sign = sign_ext & ~byte_rev;
  end
endmodule

// File: rtl/load_result_fmt.sv
module load_result_fmt
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = LD_DATA_W,
  parameter int BYTE_W = LD_BYTE_W,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SIZES  = $clog2(NBYTES) + 1,
  localparam int SZ_W   = $clog2(SIZES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [SZ_W-1:0]   size,
  input  logic              sign_ext,
  input  logic              byte_rev,
  output logic [DATA_W-1:0] comb_result,
  output logic              comb_illegal,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  logic              use_rev, use_sign, illegal;
  logic [DATA_W-1:0] swapped, picked, extended;

  ldfmt_legal #(.SZ_W(SZ_W)) u_legal (
    .size(size), .sign_ext(sign_ext), .byte_rev(byte_rev),
    .use_rev(use_rev), .use_sign(use_sign), .illegal(illegal)
  );

  ldfmt_swap #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_swap (
    .din(raw_data), .size(size), .dout(swapped)
  );

  always_comb picked = use_rev ? swapped : raw_data;

  ldfmt_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
    .din(picked), .size(size), .sign(use_sign), .dout(extended)
  );

  always_comb begin
    comb_result  = illegal ? '0 : extended;
    comb_illegal = illegal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= comb_result;
        out_illegal <= comb_illegal;
      end
    end
  end
endmodule

// File: rtl/ldfmt_checker.sv
module ldfmt_checker #(
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] raw_data,
  input logic [SZ_W-1:0]   size,
  input logic              sign_ext,
  input logic              byte_rev,
  input logic [DATA_W-1:0] comb_result,
  input logic              comb_illegal,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    comb_illegal |-> (comb_result == '0));

  p_byte_upper_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (size == SZ_W'(0) && !sign_ext && !byte_rev) |-> (comb_result[DATA_W-1:8] == '0));

  p_dword_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (size == SZ_W'(3) && !byte_rev) |-> (comb_result == raw_data));

  p_capture_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_result == $past(comb_result)
                  && out_illegal == $past(comb_illegal)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_illegal)));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_illegal));
endmodule

bind load_result_fmt ldfmt_checker #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .raw_data(raw_data),
  .size(size), .sign_ext(sign_ext), .byte_rev(byte_rev),
  .comb_result(comb_result), .comb_illegal(comb_illegal),
  .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/sim_load_result_fmt.sv
`timescale 1ns/1ps
module sim_load_result_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] raw_data = '0;
  logic [1:0]  size = '0;
  logic        sign_ext = 1'b0;
  logic        byte_rev = 1'b0;
  logic [63:0] comb_result, out_result;
  logic        comb_illegal, out_valid, out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_result_fmt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_data(raw_data),
    .size(size), .sign_ext(sign_ext), .byte_rev(byte_rev),
    .comb_result(comb_result), .comb_illegal(comb_illegal),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic bit ref_illegal(input logic [1:0] sz, input bit se, input bit br);
    return br && (se || sz == 2'd0);
  endfunction

  function automatic logic [63:0] ref_value(input logic [63:0] raw, input logic [1:0] sz,
                                            input bit se, input bit br);
    int n;
    logic [63:0] r;
    n = 1 << sz;
    r = '0;
    if (ref_illegal(sz, se, br)) return '0;
    for (int i = 0; i < n; i++) begin
      if (br) r[8*i +: 8] = raw[8*(n-1-i) +: 8];
      else    r[8*i +: 8] = raw[8*i +: 8];
    end
    if (se && n < 8 && r[8*n-1])
      for (int b = 8*n; b < 64; b++) r[b] = 1'b1;
    return r;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one vector with the strobe high, check comb now and registered after the edge.
  task automatic apply(input string req, input logic [63:0] raw, input logic [1:0] sz,
                       input bit se, input bit br);
    logic [63:0] e;
    @(negedge clk);
    raw_data = raw; size = sz; sign_ext = se; byte_rev = br; in_valid = 1'b1;
    e = ref_value(raw, sz, se, br);
    #2;
    check64({req, " comb"}, comb_result, e);
    check64({req, " illegal"}, {63'b0, comb_illegal}, {63'b0, ref_illegal(sz, se, br)});
    @(posedge clk); #2;
    check64("R10 reg", out_result, e);
    check64("R10 valid", {63'b0, out_valid}, 64'd1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    // R11: reset wins over a strobe
    in_valid = 1'b1; raw_data = 64'hFFFF_FFFF_FFFF_FFFF; size = 2'd3;
    repeat (3) @(posedge clk);
    #2;
    check64("R11 out_result", out_result, '0);
    check64("R11 out_valid", {63'b0, out_valid}, 64'd0);
    check64("R11 out_illegal", {63'b0, out_illegal}, 64'd0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;

    apply("R1", 64'h1234_5678_9ABC_DEF0, 2'd0, 0, 0);
    apply("R2", 64'hFFFF_FFFF_FFFF_8001, 2'd1, 0, 0);
    apply("R2", 64'hFFFF_FFFF_8000_0001, 2'd2, 0, 0);
    apply("R3", 64'h0000_0000_0000_0080, 2'd0, 1, 0);
    apply("R3", 64'h0000_0000_0000_8001, 2'd1, 1, 0);
    apply("R3", 64'h0000_0000_7FFF_FFFF, 2'd2, 1, 0);
    apply("R3", 64'h0000_0000_8000_0000, 2'd2, 1, 0);
    apply("R4", 64'h8123_4567_89AB_CDEF, 2'd3, 0, 0);
    apply("R4", 64'h8123_4567_89AB_CDEF, 2'd3, 1, 0);
    apply("R5", 64'hAAAA_AAAA_AAAA_1234, 2'd1, 0, 1);
    apply("R6", 64'hAAAA_AAAA_1122_3344, 2'd2, 0, 1);
    apply("R7", 64'h0102_0304_0506_0708, 2'd3, 0, 1);
    apply("R8", 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 1);
    apply("R8", 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1, 1);
    apply("R8", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1, 1);
    apply("R9", 64'hDEAD_BEEF_CAFE_0055, 2'd0, 0, 0);
    apply("R9", 64'hDEAD_BEEF_0000_0001, 2'd2, 0, 1);

    // R10: strobe low holds the register
    held = out_result;
    @(negedge clk);
    in_valid = 1'b0; raw_data = 64'h0F0F_0F0F_0F0F_0F0F; size = 2'd3; byte_rev = 1'b0;
    @(posedge clk); #2;
    check64("R10 hold", out_result, held);
    check64("R10 valid low", {63'b0, out_valid}, 64'd0);

    for (int t = 0; t < 400; t++) begin
      apply("R1-7 random", {$urandom, $urandom}, 2'($urandom % 4), bit'($urandom % 2),
            bit'($urandom % 2));
      if (t % 7 == 0) begin
        held = out_result;
        @(negedge clk);
        in_valid = 1'b0; raw_data = {$urandom, $urandom};
        @(posedge clk); #2;
        check64("R10 hold random", out_result, held);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule